// File: doc/BRIEF.md
# Seconds Counter Timekeeper with Alarm

This block keeps time as a 32-bit count of seconds. A free-running tick enable at 32.768 kHz feeds a prescaler, and the prescaler advances the count once per second while the counter is enabled. A 32-bit alarm value is compared against the count as it advances. A match raises a sticky alarm flag. Every advance also raises a sticky one-second flag. Each flag has its own interrupt enable, and a single interrupt line reports the enabled flags.

Software reaches the block over a plain 32-bit register bus: address, write strobe, write data and combinational read data. Writes are posted into the slow timekeeping domain. A ready bit in the control word shows whether the previous write has landed, and software polls it before each new write. A general-purpose 32-bit holding register is reset to zero and is never touched by the timekeeping logic. Software can therefore store a marker there and use it to detect a loss of state.

Top module: `rtc_sec_core`

## Requirements
- R1: After reset the control word (offset 0x00) reads 0x0000_0080, with only the ready bit set. The seconds count (0x04), the alarm (0x08) and the holding register (0x34) read 0, and `irq` is low.
- R2: While counter-enable (control bit 0) is 1, the seconds count rises by exactly one for every `TICKS_PER_SEC` tick enables. While it is 0, neither the count nor the prescaler moves.
- R3: The seconds count, the alarm and the holding register take the written value when the write lands. A load of the seconds count also restarts the prescaler from zero.
- R4: An accepted write clears the ready bit (control bit 7) for `WR_CYCLES` bus cycles. The write lands on the cycle the bit returns to 1.
- R5: A write issued while the ready bit is 0 is dropped and changes no register.
- R6: Each advance of the seconds count sets the one-second flag (control bit 6).
- R7: The alarm flag (control bit 4) sets on the advance that makes the count equal to the alarm value. This happens only when alarm-enable (bit 2) and counter-enable (bit 0) are both 1. Loading the count to the alarm value does not set it.
- R8: A control write clears a flag by writing 0 to that flag's bit and keeps it by writing 1. A flag set by hardware in the same cycle stays set.
- R9: `irq` is high exactly when the one-second flag is set with its enable (bit 5) at 1, or when the alarm flag is set with its enable (bit 3) at 1.
- R10: The holding register keeps its contents across a counter-enable toggle. Unmapped offsets read 0 and ignore writes.
- R11: Two back-to-back reads of the seconds count with no second boundary between them return the same value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | One-cycle pulse per 32.768 kHz tick |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| irq | output | 1 | Interrupt request |

## Verification
On every cycle the assertions check the following:
- the one-step advance and the hold of the seconds count;
- that an accepted write drops the ready bit, and that a landed write restores it;
- that a busy-time write leaves the pending payload unchanged;
- that the alarm flag is only raised while both enables are on;
- that a flag survives any control write that does not clear it;
- that `irq` stays quiet with no flag set.

Only the bench's scenarios can show the following:
- the exact number of ticks per second and the prescaler restart on a count load;
- where the alarm match falls against the advancing count;
- the absence of an alarm on a direct load;
- the exact cycle at which a posted write lands;
- that the holding register persists across an enable toggle.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    localparam int unsigned DW = 32;

    // register offsets
    localparam logic [7:0] OFF_CTRL    = 8'h00;
    localparam logic [7:0] OFF_SEC     = 8'h04;
    localparam logic [7:0] OFF_ALARM   = 8'h08;
    localparam logic [7:0] OFF_HOLD    = 8'h34;

    // control word bit positions
    localparam int unsigned B_READY    = 7;
    localparam int unsigned B_SEC_FLG  = 6;
    localparam int unsigned B_SEC_IE   = 5;
    localparam int unsigned B_ALM_FLG  = 4;
    localparam int unsigned B_ALM_IE   = 3;
    localparam int unsigned B_ALM_EN   = 2;
    localparam int unsigned B_RUN      = 0;

    typedef struct packed {
        logic sec_flag;
        logic sec_ie;
        logic alm_flag;
        logic alm_ie;
        logic alm_en;
        logic run;
    } ctrl_t;

    typedef struct packed {
        logic [7:0]    addr;
        logic [DW-1:0] data;
    } post_t;

    function automatic logic [DW-1:0] ctrl_word(ctrl_t c, logic ready);
        logic [DW-1:0] w;
        w            = '0;
        w[B_READY]   = ready;
        w[B_SEC_FLG] = c.sec_flag;
        w[B_SEC_IE]  = c.sec_ie;
        w[B_ALM_FLG] = c.alm_flag;
        w[B_ALM_IE]  = c.alm_ie;
        w[B_ALM_EN]  = c.alm_en;
        w[B_RUN]     = c.run;
        return w;
    endfunction

    function automatic logic flag_next(logic cur, logic hw_set, logic wr, logic keep);
        return hw_set | (cur & (~wr | keep));
    endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
    parameter int unsigned TICKS_PER_SEC = 32768
) (
    input  logic clk,
    input  logic rst,
    input  logic tick_en,
    input  logic run,
    input  logic restart,
    output logic sec_pulse
);
    localparam int unsigned PW = (TICKS_PER_SEC > 2) ? $clog2(TICKS_PER_SEC) : 1;
    localparam logic [PW-1:0] LAST = PW'(TICKS_PER_SEC - 1);

    logic [PW-1:0] cnt;
    logic          wrap;

    assign wrap      = (cnt == LAST);
    assign sec_pulse = tick_en && run && wrap && !restart;

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            cnt <= '0;
        end else if (tick_en && run) begin
            cnt <= wrap ? '0 : cnt + PW'(1);
        end
    end
endmodule

// File: rtl/rtc_wr_post.sv
module rtc_wr_post
    import rtc_pkg::*;
#(
    parameter int unsigned ADDR_W    = 8,
    parameter int unsigned WR_CYCLES = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DW-1:0]     wdata,
    output logic              ready,
    output logic              commit,
    output post_t             pend
);
    localparam int unsigned CW = $clog2(WR_CYCLES + 1);

    logic [CW-1:0] busy;

    assign ready  = (busy == '0);
    assign commit = (busy == CW'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= '0;
            pend <= '0;
        end else if (we && ready) begin
            busy      <= CW'(WR_CYCLES);
            pend.addr <= 8'(addr);
            pend.data <= wdata;
        end else if (!ready) begin
            busy <= busy - CW'(1);
        end
    end
endmodule

// File: rtl/rtc_timekeep.sv
module rtc_timekeep
    import rtc_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          sec_pulse,
    input  logic          ld_sec,
    input  logic          ld_alarm,
    input  logic          ld_ctrl,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] seconds,
    output logic [DW-1:0] alarm,
    output ctrl_t         ctrl
);
    logic [DW-1:0] sec_inc;
    logic          alm_hit;

    assign sec_inc = seconds + DW'(1);
    assign alm_hit = sec_pulse && ctrl.alm_en && (sec_inc == alarm);

    always_ff @(posedge clk) begin
        if (rst) begin
            seconds <= '0;
            alarm   <= '0;
            ctrl    <= '0;
        end else begin
            if (ld_sec)         seconds <= wdata;
            else if (sec_pulse) seconds <= sec_inc;
            if (ld_alarm)       alarm   <= wdata;
            if (ld_ctrl) begin
                ctrl.run    <= wdata[B_RUN];
                ctrl.alm_en <= wdata[B_ALM_EN];
                ctrl.alm_ie <= wdata[B_ALM_IE];
                ctrl.sec_ie <= wdata[B_SEC_IE];
            end
            ctrl.sec_flag <= flag_next(ctrl.sec_flag, sec_pulse, ld_ctrl, wdata[B_SEC_FLG]);
            ctrl.alm_flag <= flag_next(ctrl.alm_flag, alm_hit,   ld_ctrl, wdata[B_ALM_FLG]);
        end
    end
endmodule

// File: rtl/rtc_sec_core.sv
module rtc_sec_core
    import rtc_pkg::*;
#(
    parameter int unsigned ADDR_W        = 8,
    parameter int unsigned TICKS_PER_SEC = 32768,
    parameter int unsigned WR_CYCLES     = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_en,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    output logic              irq
);
    logic          wr_ready;
    logic          commit;
    post_t         pend;
    logic          ld_sec, ld_alarm, ld_ctrl, ld_hold;
    logic          sec_pulse;
    logic [DW-1:0] seconds, alarm, hold;
    ctrl_t         ctrl;

    rtc_wr_post #(.ADDR_W(ADDR_W), .WR_CYCLES(WR_CYCLES)) u_post (
        .clk(clk), .rst(rst), .we(bus_we), .addr(bus_addr), .wdata(bus_wdata),
        .ready(wr_ready), .commit(commit), .pend(pend)
    );

    assign ld_ctrl  = commit && (pend.addr == OFF_CTRL);
    assign ld_sec   = commit && (pend.addr == OFF_SEC);
    assign ld_alarm = commit && (pend.addr == OFF_ALARM);
    assign ld_hold  = commit && (pend.addr == OFF_HOLD);

    rtc_prescaler #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_presc (
        .clk(clk), .rst(rst), .tick_en(tick_en), .run(ctrl.run),
        .restart(ld_sec), .sec_pulse(sec_pulse)
    );

    rtc_timekeep u_tk (
        .clk(clk), .rst(rst), .sec_pulse(sec_pulse), .ld_sec(ld_sec),
        .ld_alarm(ld_alarm), .ld_ctrl(ld_ctrl), .wdata(pend.data),
        .seconds(seconds), .alarm(alarm), .ctrl(ctrl)
    );

    always_ff @(posedge clk) begin
        if (rst)          hold <= '0;
        else if (ld_hold) hold <= pend.data;
    end

    always_comb begin
        unique case (8'(bus_addr))
            OFF_CTRL:  bus_rdata = ctrl_word(ctrl, wr_ready);
            OFF_SEC:   bus_rdata = seconds;
            OFF_ALARM: bus_rdata = alarm;
            OFF_HOLD:  bus_rdata = hold;
            default:   bus_rdata = '0;
        endcase
    end

    assign irq = (ctrl.sec_flag && ctrl.sec_ie) || (ctrl.alm_flag && ctrl.alm_ie);
endmodule

// File: rtl/rtc_sec_core_chk.sv
module rtc_sec_core_chk
    import rtc_pkg::*;
(
    input logic          clk,
    input logic          rst,
    input logic          bus_we,
    input logic          wr_ready,
    input logic          commit,
    input post_t         pend,
    input logic          ld_sec,
    input logic          ld_ctrl,
    input logic          sec_pulse,
    input logic [DW-1:0] seconds,
    input ctrl_t         ctrl,
    input logic          irq
);
    AST_SEC_STEP: assert property (@(posedge clk) disable iff (rst)
        sec_pulse && !ld_sec |=> seconds == $past(seconds) + DW'(1)); // R2
    AST_SEC_HOLD: assert property (@(posedge clk) disable iff (rst)
        !sec_pulse && !ld_sec |=> $stable(seconds)); // R2
    AST_READY_DROP: assert property (@(posedge clk) disable iff (rst)
        bus_we && wr_ready |=> !wr_ready); // R4
    AST_READY_BACK: assert property (@(posedge clk) disable iff (rst)
        commit |=> wr_ready); // R4
    AST_BUSY_DROP: assert property (@(posedge clk) disable iff (rst)
        bus_we && !wr_ready |=> $stable(pend)); // R5
    AST_SEC_FLAG: assert property (@(posedge clk) disable iff (rst)
        sec_pulse |=> ctrl.sec_flag); // R6
    AST_ALARM_GATE: assert property (@(posedge clk) disable iff (rst)
        $rose(ctrl.alm_flag) |-> $past(ctrl.alm_en && ctrl.run)); // R7
    AST_ALARM_KEEP: assert property (@(posedge clk) disable iff (rst)
        ctrl.alm_flag && !(ld_ctrl && !pend.data[B_ALM_FLG]) |=> ctrl.alm_flag); // R8
    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (rst)
        !ctrl.sec_flag && !ctrl.alm_flag |-> !irq); // R9
endmodule

bind rtc_sec_core rtc_sec_core_chk u_chk (
    .clk(clk), .rst(rst), .bus_we(bus_we), .wr_ready(wr_ready), .commit(commit),
    .pend(pend), .ld_sec(ld_sec), .ld_ctrl(ld_ctrl), .sec_pulse(sec_pulse),
    .seconds(seconds), .ctrl(ctrl), .irq(irq)
);

// File: tb/rtc_sec_core_bench.sv
module rtc_sec_core_bench;
    localparam int unsigned T  = 8;
    localparam int unsigned WC = 4;
    localparam logic [7:0] A_CTRL = 8'h00, A_SEC = 8'h04, A_ALM = 8'h08, A_HOLD = 8'h34;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick_en = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int total = 0;
    int fails = 0;
    bit done  = 0;

    typedef struct {
        bit          is_irq;
        logic [31:0] exp;
        logic [31:0] mask;
        string       tag;
    } item_t;
    item_t sbq[$];

    always #2 clk = ~clk;

    rtc_sec_core #(.ADDR_W(8), .TICKS_PER_SEC(T), .WR_CYCLES(WC)) u_rtc_sec_core (
        .clk(clk), .rst(rst), .tick_en(tick_en), .bus_addr(bus_addr),
        .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    // monitor: compares one queued item per falling edge
    always @(negedge clk) begin
        if (sbq.size() > 0) begin
            item_t it;
            logic [31:0] act;
            it  = sbq.pop_front();
            act = it.is_irq ? {31'b0, irq} : (bus_rdata & it.mask);
            total++;
            if (act !== (it.exp & it.mask)) begin
                fails++;
                $display("FAIL %s: actual 0x%08h expected 0x%08h", it.tag, act, it.exp & it.mask);
            end
        end
    end

    task automatic push_now(bit is_irq, logic [31:0] exp, logic [31:0] mask, string tag);
        item_t it;
        it.is_irq = is_irq; it.exp = exp; it.mask = mask; it.tag = tag;
        sbq.push_back(it);
        @(negedge clk); #1;
    endtask

    task automatic expect_reg(logic [7:0] a, logic [31:0] exp, string tag);
        @(posedge clk); bus_addr <= a;
        push_now(0, exp, 32'hFFFF_FFFF, tag);
    endtask

    task automatic expect_irq(logic v, string tag);
        push_now(1, {31'b0, v}, 32'h1, tag);
    endtask

    task automatic wait_ready();
        @(posedge clk); bus_addr <= A_CTRL;
        do @(negedge clk); while (!bus_rdata[7]);
    endtask

    task automatic raw_write(logic [7:0] a, logic [31:0] d, logic [7:0] after);
        @(posedge clk); bus_we <= 1'b1; bus_addr <= a; bus_wdata <= d;
        @(posedge clk); bus_we <= 1'b0; bus_addr <= after;
    endtask

    task automatic bus_write(logic [7:0] a, logic [31:0] d);
        wait_ready();
        raw_write(a, d, A_CTRL);
        wait_ready();
    endtask

    task automatic ticks(int n);
        repeat (n) begin
            @(posedge clk); tick_en <= 1'b1;
            @(posedge clk); tick_en <= 1'b0;
        end
        @(posedge clk);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] s1;
        repeat (3) @(posedge clk);
        rst <= 1'b0;
        @(posedge clk);

        // R1 reset state
        expect_reg(A_CTRL, 32'h80, "R1 ctrl");
        expect_reg(A_SEC,  32'h0,  "R1 seconds");
        expect_reg(A_ALM,  32'h0,  "R1 alarm");
        expect_reg(A_HOLD, 32'h0,  "R1 hold");
        expect_irq(1'b0, "R1 irq");

        // R4 ready window, write lands when ready returns
        wait_ready();
        raw_write(A_HOLD, 32'hCAFE_0001, A_CTRL);
        for (int i = 0; i < WC; i++) push_now(0, 32'h0, 32'h80, "R4 ready low");
        push_now(0, 32'h80, 32'h80, "R4 ready back");
        expect_reg(A_HOLD, 32'hCAFE_0001, "R3 hold load");

        // R5 write while busy is dropped
        wait_ready();
        raw_write(A_HOLD, 32'h1111_0000, A_HOLD);
        raw_write(A_HOLD, 32'h2222_0000, A_HOLD);
        wait_ready();
        expect_reg(A_HOLD, 32'h1111_0000, "R5 busy write dropped");

        // R2 hold while disabled
        bus_write(A_SEC, 32'd100);
        ticks(2 * T);
        expect_reg(A_SEC, 32'd100, "R2 hold when disabled");

        // R2/R6 counting
        bus_write(A_CTRL, 32'h01);
        expect_reg(A_CTRL, 32'h81, "R2 enable");
        bus_write(A_SEC, 32'd100);
        ticks(T);
        expect_reg(A_SEC, 32'd101, "R2 one second");
        expect_reg(A_CTRL, 32'hC1, "R6 second flag");
        expect_irq(1'b0, "R9 flag without enable");
        ticks(T - 1);
        expect_reg(A_SEC, 32'd101, "R2 one tick short");
        ticks(1);
        expect_reg(A_SEC, 32'd102, "R2 boundary tick");

        // R11 consecutive reads agree
        @(posedge clk); bus_addr <= A_SEC;
        @(negedge clk); s1 = bus_rdata;
        push_now(0, s1, 32'hFFFF_FFFF, "R11 second read");
        push_now(0, 32'd102, 32'hFFFF_FFFF, "R11 value");

        // R8/R9 keep and clear
        bus_write(A_CTRL, 32'h61);
        expect_reg(A_CTRL, 32'hE1, "R8 write one keeps flag");
        expect_irq(1'b1, "R9 second irq");
        bus_write(A_CTRL, 32'h21);
        expect_reg(A_CTRL, 32'hA1, "R8 write zero clears flag");
        expect_irq(1'b0, "R9 irq after clear");

        // R7 alarm match
        bus_write(A_ALM, 32'd105);
        expect_reg(A_ALM, 32'd105, "R3 alarm load");
        bus_write(A_CTRL, 32'h0D);
        expect_reg(A_CTRL, 32'h8D, "R7 alarm armed");
        ticks(T);
        expect_reg(A_SEC, 32'd103, "R2 count 103");
        expect_reg(A_CTRL, 32'hCD, "R7 no alarm before match");
        expect_irq(1'b0, "R9 second flag masked");
        ticks(T);
        expect_reg(A_CTRL, 32'hCD, "R7 no alarm at 104");
        ticks(T);
        expect_reg(A_SEC, 32'd105, "R2 count 105");
        expect_reg(A_CTRL, 32'hDD, "R7 alarm flag at match");
        expect_irq(1'b1, "R9 alarm irq");

        // R7 gate: alarm-enable off
        bus_write(A_CTRL, 32'h01);
        expect_reg(A_CTRL, 32'h81, "R8 both flags cleared");
        expect_irq(1'b0, "R9 irq low");
        bus_write(A_SEC, 32'd200);
        bus_write(A_ALM, 32'd201);
        ticks(T);
        expect_reg(A_SEC, 32'd201, "R2 count 201");
        expect_reg(A_CTRL, 32'hC1, "R7 no alarm when disabled");

        // R7 direct load to alarm value
        bus_write(A_CTRL, 32'h05);
        bus_write(A_SEC, 32'd201);
        expect_reg(A_CTRL, 32'h85, "R7 load equal no flag");

        // R3 load restarts prescaler
        ticks(T / 2);
        expect_reg(A_SEC, 32'd201, "R3 partial second");
        bus_write(A_SEC, 32'd300);
        ticks(T - 1);
        expect_reg(A_SEC, 32'd300, "R3 prescaler restarted");
        ticks(1);
        expect_reg(A_SEC, 32'd301, "R3 full second after load");
        expect_reg(A_CTRL, 32'hC5, "R7 no alarm off match");

        // R10 holding register persistence and unmapped offsets
        bus_write(A_CTRL, 32'h00);
        bus_write(A_CTRL, 32'h01);
        expect_reg(A_HOLD, 32'h1111_0000, "R10 hold survives toggle");
        expect_reg(8'h10, 32'h0, "R10 unmapped reads zero");
        bus_write(8'h10, 32'hDEAD_BEEF);
        expect_reg(A_HOLD, 32'h1111_0000, "R10 unmapped write ignored");
        expect_reg(A_SEC, 32'd301, "R10 seconds untouched");

        repeat (2) @(posedge clk);
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end
endmodule